// File: doc/BRIEF.md
# Fly-by DMA Channel Engine

This block is a single channel of a fly-by DMA controller placed between one I/O device and system memory. Software writes a base address, a base count and a mode word through a narrow register port, then clears the channel mask. When the device raises its request, the channel asks for the bus. Once the grant arrives it acknowledges the device and runs bus cycles. Each bus cycle drives the memory address together with one read strobe and one write strobe. The data word passes straight from the device to memory, or from memory to the device, in that single cycle and never enters the block.

Four service modes are available: single, block, demand and cascade. Cascade lets an external bus master take the bus after the handshake. A compressed timing option shortens each transfer. A terminal-count output marks the last transfer of a programmed run. No data stream crosses the block, so it has no valid/ready interface. All pins are plain levels. The device holds its request level for as long as it wants service, and the channel never buffers a transfer.

Top module: `dma_chan`

## Requirements
- R1: After reset and with the mask clear, a high `dev_req` raises `bus_req` on the next clock. `dev_ack` is high only while `bus_grant` is high. It goes high on the clock after a grant is seen.
- R2: With normal timing, every transfer lasts four clocks in the order upper-address, read, read+write, end. `addr_oe` is high in all four clocks and `upper_stb` in the first.
- R3: With compressed timing (mode bit 5), a transfer lasts two clocks (read, read+write). A third leading `upper_stb` clock is added for the first transfer after a grant, and whenever bits 15..8 of the new address differ from the previous transfer.
- R4: Single service (mode bits 1:0 = 01) drops `bus_req` and `dev_ack` after each transfer. A new request cycle is needed for every byte.
- R5: Block service (bits 1:0 = 10) keeps transferring until terminal count, whatever `dev_req` does.
- R6: Demand service (bits 1:0 = 00) releases the bus at the end of a transfer if `dev_req` is low at that clock. It later resumes at the next address and remaining count.
- R7: Cascade service (bits 1:0 = 11) asserts `dev_ack` after the grant with `addr_oe` and all four strobes low. It releases one clock after `dev_req` falls.
- R8: Mode bit 4 set pairs `io_rd` with `mem_wr`. Clear pairs `mem_rd` with `io_wr`. In both cases the read strobe covers the read and read+write clocks, and the write strobe covers the read+write clock only.
- R9: The address steps by one per transfer: up when mode bit 2 is 0, down when it is 1. It wraps within 16 bits.
- R10: A count value C gives C+1 transfers. `tc` is high during every clock of the last one. Afterwards the mask is set, unless mode bit 3 (auto-initialize) is set, in which case the base address and count are reloaded.
- R11: Register select 0 loads the base and current address, 1 the base and current count, 2 the mode (bits 5:0), and 3 the mask (bit 0). Reset leaves the mask set, so requests are ignored and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| dev_req | input | 1 | Device service request |
| dev_ack | output | 1 | Acknowledge to the device |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| addr | output | 16 | Memory address, valid while `addr_oe` |
| addr_oe | output | 1 | Channel is driving the address |
| upper_stb | output | 1 | Upper address byte is being re-driven |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| tc | output | 1 | Last transfer of the programmed count |

## Verification
On every cycle the assertions check the following:
- the grant precedes the acknowledge;
- a request rises only from an unmasked device request;
- the write strobe never appears without its paired read strobe;
- cascade stays quiet on the address and strobe pins;
- the address holds steady within a transfer and steps correctly between transfers;
- terminal count ends in either a mask or a reload.

Only the bench scenarios can show the whole-run behaviours: the phase counts for each timing, the extra compressed clock at a byte boundary, a demand pause and its resume from the right address, single-mode re-requests, and auto-initialize restarting at the base.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SVC_DEMAND  = 2'd0,
    SVC_SINGLE  = 2'd1,
    SVC_BLOCK   = 2'd2,
    SVC_CASCADE = 2'd3
  } svc_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_UP,
    PH_RD,
    PH_RW,
    PH_END,
    PH_CASC
  } phase_e;

  // bit5 compress, bit4 to_mem, bit3 autoinit, bit2 down, bits1:0 service
  typedef struct packed {
    logic compress;
    logic to_mem;
    logic autoinit;
    logic down;
    svc_e svc;
  } mode_t;

  localparam int MODE_W = 6;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output mode_t             mode,
  output logic              mask
);

  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);

  logic [ADDR_W-1:0] base_addr;
  logic [CNT_W-1:0]  base_cnt;
  logic              last_xfer;

  assign next_addr = mode.down ? (cur_addr - ONE_A) : (cur_addr + ONE_A);
  assign last_xfer = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= '0;
      mask      <= 1'b1;
    end else if (we) begin
      case (sel)
        2'd0: begin
          base_addr <= wdata[ADDR_W-1:0];
          cur_addr  <= wdata[ADDR_W-1:0];
        end
        2'd1: begin
          base_cnt <= wdata[CNT_W-1:0];
          cur_cnt  <= wdata[CNT_W-1:0];
        end
        2'd2:    mode <= mode_t'(wdata[MODE_W-1:0]);
        default: mask <= wdata[0];
      endcase
    end else if (step) begin
      if (last_xfer && mode.autoinit) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= next_addr;
        cur_cnt  <= cur_cnt - ONE_C;
        if (last_xfer) mask <= 1'b1;
      end
    end
  end

  // R9: one step per transfer, in the programmed direction
  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !we && !last_xfer) |=>
      (cur_addr == ($past(mode.down) ? $past(cur_addr) - ONE_A : $past(cur_addr) + ONE_A)));

  // R10: terminal count without auto-initialize masks the channel
  a_r10_tc_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !we && last_xfer && !mode.autoinit) |=> mask);

  // R10: terminal count with auto-initialize restores the base values
  a_r10_autoinit_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !we && last_xfer && mode.autoinit) |=>
      (cur_addr == $past(base_addr) && cur_cnt == $past(base_cnt) && !mask));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int UP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dev_req,
  input  logic            bus_grant,
  input  mode_t           mode,
  input  logic            mask,
  input  logic            cnt_zero,
  input  logic [UP_W-1:0] cur_up,
  input  logic [UP_W-1:0] next_up,
  output logic            bus_req,
  output logic            dev_ack,
  output logic            addr_oe,
  output logic            upper_stb,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            io_rd,
  output logic            io_wr,
  output logic            tc,
  output logic            step
);

  phase_e state, state_n, cont_ph, after_ph;
  logic   go_on, rd_ph, wr_ph, in_xfer;

  assign in_xfer = (state == PH_UP) || (state == PH_RD) ||
                   (state == PH_RW) || (state == PH_END);
  assign step    = mode.compress ? (state == PH_RW) : (state == PH_END);

  assign go_on = !cnt_zero && (mode.svc != SVC_SINGLE) &&
                 !((mode.svc == SVC_DEMAND) && !dev_req);
  assign cont_ph  = (!mode.compress || (next_up != cur_up)) ? PH_UP : PH_RD;
  assign after_ph = go_on ? cont_ph : PH_IDLE;

  always_comb begin
    state_n = state;
    case (state)
      PH_IDLE: if (!mask && dev_req) state_n = PH_REQ;
      PH_REQ:  if (bus_grant) state_n = (mode.svc == SVC_CASCADE) ? PH_CASC : PH_UP;
      PH_UP:   state_n = PH_RD;
      PH_RD:   state_n = PH_RW;
      PH_RW:   state_n = mode.compress ? after_ph : PH_END;
      PH_END:  state_n = after_ph;
      PH_CASC: if (!dev_req) state_n = PH_IDLE;
      default: state_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PH_IDLE;
    else        state <= state_n;
  end

  assign rd_ph     = (state == PH_RD) || (state == PH_RW);
  assign wr_ph     = (state == PH_RW);
  assign bus_req   = (state != PH_IDLE);
  assign dev_ack   = in_xfer || (state == PH_CASC);
  assign addr_oe   = in_xfer;
  assign upper_stb = (state == PH_UP);
  assign io_rd     = mode.to_mem  && rd_ph;
  assign mem_wr    = mode.to_mem  && wr_ph;
  assign mem_rd    = !mode.to_mem && rd_ph;
  assign io_wr     = !mode.to_mem && wr_ph;
  assign tc        = in_xfer && cnt_zero;

  // R1: acknowledge only under a grant
  a_r1_ack_granted: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> bus_grant);

  // R1: a bus request starts only from an unmasked device request
  a_r1_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> ($past(dev_req) && !$past(mask)));

  // R8: write strobes ride inside their paired read strobe
  a_r8_memwr_pair: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (io_rd && !mem_rd));
  a_r8_iowr_pair: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> (mem_rd && !io_rd));

  // R7: acknowledge without address drive means no strobes at all
  a_r7_cascade_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && !addr_oe) |-> !(mem_rd || mem_wr || io_rd || io_wr || upper_stb));

  // R4: single service gives the bus back after each transfer
  a_r4_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mode.svc == SVC_SINGLE) |=> !dev_ack);

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              dev_req,
  output logic              dev_ack,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_oe,
  output logic              upper_stb,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              tc
);

  localparam int UP_W = ADDR_W - 8;

  logic [ADDR_W-1:0] cur_addr, next_addr;
  logic [CNT_W-1:0]  cur_cnt;
  mode_t             mode;
  logic              mask, step, cnt_zero;

  assign cnt_zero = (cur_cnt == '0);
  assign addr     = cur_addr;

  dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .step(step), .cur_addr(cur_addr), .next_addr(next_addr), .cur_cnt(cur_cnt),
    .mode(mode), .mask(mask)
  );

  dma_chan_seq #(.UP_W(UP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .bus_grant(bus_grant),
    .mode(mode), .mask(mask), .cnt_zero(cnt_zero),
    .cur_up(cur_addr[ADDR_W-1:8]), .next_up(next_addr[ADDR_W-1:8]),
    .bus_req(bus_req), .dev_ack(dev_ack), .addr_oe(addr_oe), .upper_stb(upper_stb),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .tc(tc), .step(step)
  );

  // R2: the address holds for every clock of one transfer
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe && $past(addr_oe) && !$past(step)) |-> $stable(addr));

endmodule

// File: tb/dma_chan_tb.sv
module dma_chan_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        dev_req = 1'b0;
  logic        bus_grant = 1'b0;
  logic        dev_ack, bus_req, addr_oe, upper_stb;
  logic        mem_rd, mem_wr, io_rd, io_wr, tc;
  logic [15:0] addr;

  always #4 clk = ~clk;

  dma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .bus_req(bus_req), .bus_grant(bus_grant),
    .addr(addr), .addr_oe(addr_oe), .upper_stb(upper_stb), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .tc(tc)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // arbiter: grants half a clock after the request
  always @(negedge clk) begin
    #1 bus_grant = bus_req;
  end

  // ---------------- behavioural reference model ----------------
  int m_st;            // 0 idle, 1 requesting, 2 cascade, 3 transferring
  int q[$];            // remaining phases of the transfer: 1 up, 2 rd, 3 rw, 4 end
  int ba, bc, ca, cc, md, msk, lastup;

  function automatic void build();
    q.delete();
    if (((md >> 5) & 1) == 0) begin
      q.push_back(1); q.push_back(2); q.push_back(3); q.push_back(4);
    end else begin
      if ((ca >> 8) != lastup) q.push_back(1);
      q.push_back(2); q.push_back(3);
    end
    lastup = ca >> 8;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; q.delete(); ba = 0; bc = 0; ca = 0; cc = 0; md = 0; msk = 1; lastup = -1;
    end else begin
      automatic int svc = md & 3;
      case (m_st)
        0: if (!msk && dev_req) m_st = 1;
        1: if (bus_grant) begin
             if (svc == 3) m_st = 2;
             else begin m_st = 3; lastup = -1; build(); end
           end
        2: if (!dev_req) m_st = 0;
        default: begin
          void'(q.pop_front());
          if (q.size() == 0) begin
            automatic bit last = (cc == 0);
            ca = ((md >> 2) & 1) ? ((ca - 1) & 'hFFFF) : ((ca + 1) & 'hFFFF);
            cc = (cc - 1) & 'hFFFF;
            if (last) begin
              if ((md >> 3) & 1) begin ca = ba; cc = bc; end
              else msk = 1;
              m_st = 0;
            end else if (svc == 1 || (svc == 0 && !dev_req)) m_st = 0;
            else build();
          end
        end
      endcase
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin ba = cfg_wdata; ca = cfg_wdata; end
          2'd1: begin bc = cfg_wdata; cc = cfg_wdata; end
          2'd2: md = cfg_wdata & 'h3F;
          default: msk = cfg_wdata & 1;
        endcase
      end
    end
  end

  // ---------------- per-clock comparison and scenario counters ----------------
  int n_wr, n_ack, n_up, n_rise, n_casc;
  logic prev_req = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic int ph  = (m_st == 3) ? q[0] : 0;
      automatic int oe  = (m_st == 3);
      automatic int rd  = (ph == 2 || ph == 3);
      automatic int wr  = (ph == 3);
      automatic int tom = (md >> 4) & 1;
      chk("R1 bus_req", bus_req, m_st != 0);
      chk("R1 dev_ack", dev_ack, m_st >= 2);
      chk("R2 addr_oe", addr_oe, oe);
      chk("R3 upper_stb", upper_stb, ph == 1);
      chk("R8 io_rd", io_rd, tom && rd);
      chk("R8 mem_wr", mem_wr, tom && wr);
      chk("R8 mem_rd", mem_rd, !tom && rd);
      chk("R8 io_wr", io_wr, !tom && wr);
      chk("R10 tc", tc, oe && cc == 0);
      if (oe) chk("R9 addr", addr, ca);
      if (mem_wr || io_wr) n_wr++;
      if (dev_ack) n_ack++;
      if (upper_stb) n_up++;
      if (bus_req && !prev_req) n_rise++;
      if (dev_ack && !addr_oe) n_casc++;
    end
    prev_req = bus_req;
  end

  task automatic clr();
    n_wr = 0; n_ack = 0; n_up = 0; n_rise = 0; n_casc = 0;
  endtask

  task automatic wcfg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #2; end
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #2; end while (bus_req || dev_ack);
  endtask

  task automatic wait_wr(input int n);
    do begin @(negedge clk); #2; end while (n_wr < n);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clr();
    repeat (4) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk); #2;
    // R11: reset state is quiet
    chk("R11 reset outputs", {bus_req, dev_ack, addr_oe, upper_stb, mem_rd, mem_wr, io_rd, io_wr, tc}, 0);
    dev_req = 1'b1; cyc(5); dev_req = 1'b0;
    chk("R11 masked request ignored", n_rise, 0);

    // R5/R2: block, normal timing, device to memory, upward across a byte boundary
    wcfg(2'd0, 16'h12FE); wcfg(2'd1, 16'd3); wcfg(2'd2, 16'h0012); wcfg(2'd3, 16'h0000);
    clr(); dev_req = 1'b1; cyc(2); dev_req = 1'b0; wait_idle();
    chk("R5 block transfers", n_wr, 4);
    chk("R2 normal clocks", n_ack, 16);
    chk("R2 upper phase per transfer", n_up, 4);
    clr(); dev_req = 1'b1; cyc(4); dev_req = 1'b0; cyc(2);
    chk("R10 masked after tc", n_rise, 0);

    // R3: compressed block, boundary 0x01FF -> 0x0200
    wcfg(2'd0, 16'h01FE); wcfg(2'd1, 16'd4); wcfg(2'd2, 16'h0032); wcfg(2'd3, 16'h0000);
    clr(); dev_req = 1'b1; cyc(2); dev_req = 1'b0; wait_idle();
    chk("R3 compressed transfers", n_wr, 5);
    chk("R3 compressed clocks", n_ack, 12);
    chk("R3 upper re-drives", n_up, 2);

    // R3/R9: compressed upward wrap 0xFFFF -> 0x0000
    wcfg(2'd0, 16'hFFFF); wcfg(2'd1, 16'd1); wcfg(2'd3, 16'h0000);
    clr(); dev_req = 1'b1; cyc(2); dev_req = 1'b0; wait_idle();
    chk("R9 wrap transfers", n_wr, 2);
    chk("R3 wrap upper re-drive", n_up, 2);

    // R4/R10: single, downward, auto-initialize, memory to device, wrap 0x0000 -> 0xFFFF
    wcfg(2'd0, 16'h0001); wcfg(2'd1, 16'd2); wcfg(2'd2, 16'h000D); wcfg(2'd3, 16'h0000);
    clr(); dev_req = 1'b1; wait_wr(4); dev_req = 1'b0; wait_idle();
    chk("R4 one request per byte", n_rise, 4);
    chk("R10 autoinit kept running", n_wr, 4);

    // R6: demand pause and resume
    wcfg(2'd0, 16'h0040); wcfg(2'd1, 16'd7); wcfg(2'd2, 16'h0010); wcfg(2'd3, 16'h0000);
    clr(); dev_req = 1'b1; wait_wr(2); dev_req = 1'b0; wait_idle(); cyc(5);
    chk("R6 paused count", n_wr, 2);
    chk("R6 bus released", bus_req, 0);
    dev_req = 1'b1; wait_wr(8); wait_idle(); dev_req = 1'b0; cyc(3);
    chk("R6 resumed to end", n_wr, 8);

    // R7: cascade hand-over
    wcfg(2'd2, 16'h0003); wcfg(2'd3, 16'h0000);
    clr(); dev_req = 1'b1; cyc(10); dev_req = 1'b0; wait_idle();
    chk("R7 cascade ack clocks", n_casc, 9);
    chk("R7 cascade no strobes", n_wr + n_up, 0);

    cyc(3);
    finish_run();
  end

endmodule